// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic unit of a small 8-bit microcontroller core. Each clock it takes a 16-bit instruction word and the two operand bytes the core has already read from its 32-entry register file. It also takes the current status byte. One clock later it presents four things: the destination register index, the result byte, a write enable, and the new status byte. The core writes the result back and keeps the status byte. The register file, instruction fetch and branching belong to the surrounding core.

Two instruction forms are decoded. The first is a two-register add that includes the carry. The second is a group of single-operand operations: bitwise invert, negate, increment, decrement, and three right shifts (arithmetic, logical, and rotate through carry). Each operation has its own rule for which flags it writes. A flag that an operation does not define keeps its incoming value.

Top module: `alu8_flags`

## Requirements
- R1: While `rst_n` is low, `dst_idx`, `result`, `wr_en` and `flags_out` are all zero.
- R2: Outputs appear on the clock edge after their inputs are sampled.
  - The add is recognised when `instr[15:10]` = 6'b000111.
  - The single-operand group is recognised when `instr[15:9]` = 7'b1001010, with `instr[3:0]` selecting the operation: 0 invert, 1 negate, 3 increment, 5 arithmetic shift, 6 logical shift, 7 rotate, 10 decrement.
  - For these instructions `wr_en` is 1 and `dst_idx` equals `instr[8:4]`.
- R3: The status byte layout is C=bit0, Z=bit1, N=bit2, V=bit3, S=bit4, H=bit5, T=bit6, I=bit7.
  - Bits 7:6 always pass through unchanged.
  - For every decoded operation, Z is set exactly when the result is zero, N equals result bit 7, and S equals N xor V.
- R4: The add gives result = (a + b + C) mod 256.
  - C is the carry out of bit 7.
  - V is set when a and b share a sign bit that differs from the result's.
  - H is the carry out of bit 3 with the incoming C included.
- R5: Invert gives result = ~a, V = 0 and C = 1. H is unchanged.
- R6: Negate gives result = (0 - a) mod 256.
  - C = 1 exactly when the result is non-zero.
  - V = 1 exactly when the result is 0x80.
  - H = result bit 3 OR a bit 3.
- R7: Increment gives result = a + 1 mod 256, with V = 1 exactly when the result is 0x80. C and H are unchanged.
- R8: Decrement gives result = a - 1 mod 256, with V = 1 exactly when a was 0x80. C and H are unchanged.
- R9: Arithmetic shift gives result = {a[7], a[7:1]}, C = a[0] and V = N xor C. H is unchanged.
- R10: Logical shift gives result = {0, a[7:1]}, C = a[0] and V = N xor C. H is unchanged.
- R11: Rotate gives result = {old C, a[7:1]}, C = a[0] and V = N xor C. H is unchanged.
- R12: Any other instruction word (including unused selector codes in the single-operand group) gives `wr_en` = 0 and `flags_out` equal to the sampled `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 16 | Instruction word |
| opd_a | input | 8 | Destination register operand |
| opd_b | input | 8 | Source register operand (add only) |
| flags_in | input | 8 | Current status byte |
| dst_idx | output | 5 | Destination register index |
| result | output | 8 | Result byte |
| wr_en | output | 1 | Result write enable |
| flags_out | output | 8 | Updated status byte |

## Verification
The hardest cases to reach are the narrow flag corners. The add has a half-carry that appears only through the incoming carry, and signed overflow that needs matching operand signs. Negate and increment set V only on the single 0x80 result, and decrement only on the 0x80 operand. The bench reaches all of these by sweeping the add over every operand pair with both carry values, and every single-operand operation over all 256 operands with both carry values. At the same time it varies the pass-through status bits from a hash of the operands, so that "unchanged" flags are seen holding both 0 and 1.

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] instr,
  input  logic [7:0]  opd_a,
  input  logic [7:0]  opd_b,
  input  logic [7:0]  flags_in,
  output logic [4:0]  dst_idx,
  output logic [7:0]  result,
  output logic        wr_en,
  output logic [7:0]  flags_out
);
  localparam int FC = 0, FZ = 1, FN = 2, FV = 3, FS = 4, FH = 5;

  wire is_add = instr[15:10] == 6'b000111;
  wire is_one = instr[15:9] == 7'b1001010;
  wire cin    = flags_in[FC];

  logic [7:0] n_res, n_flg;
  logic       n_wr;
  logic [8:0] sum9;
  logic [4:0] sum5;

  always_comb begin
    n_res = 8'h00;
    n_flg = flags_in;
    n_wr  = 1'b0;
    sum9  = {1'b0, opd_a} + {1'b0, opd_b} + {8'h00, cin};
    sum5  = {1'b0, opd_a[3:0]} + {1'b0, opd_b[3:0]} + {4'h0, cin};
    if (is_add) begin
      n_wr = 1'b1;
      n_res = sum9[7:0];
      n_flg[FC] = sum9[8];
      n_flg[FH] = sum5[4];
      n_flg[FV] = (opd_a[7] == opd_b[7]) && (sum9[7] != opd_a[7]);
    end else if (is_one) begin
      n_wr = 1'b1;
      case (instr[3:0])
        4'h0: begin
          n_res = ~opd_a;
          n_flg[FV] = 1'b0;
          n_flg[FC] = 1'b1;
        end
        4'h1: begin
          n_res = 8'h00 - opd_a;
          n_flg[FC] = n_res != 8'h00;
          n_flg[FV] = n_res == 8'h80;
          n_flg[FH] = n_res[3] | opd_a[3];
        end
        4'h3: begin
          n_res = opd_a + 8'h01;
          n_flg[FV] = n_res == 8'h80;
        end
        4'ha: begin
          n_res = opd_a - 8'h01;
          n_flg[FV] = opd_a == 8'h80;
        end
        4'h5, 4'h6, 4'h7: begin
          case (instr[1:0])
            2'b01:   n_res = {opd_a[7], opd_a[7:1]};
            2'b10:   n_res = {1'b0, opd_a[7:1]};
            default: n_res = {cin, opd_a[7:1]};
          endcase
          n_flg[FC] = opd_a[0];
          n_flg[FV] = n_res[7] ^ opd_a[0];
        end
        default: n_wr = 1'b0;
      endcase
    end
    if (n_wr) begin
      n_flg[FZ] = n_res == 8'h00;
      n_flg[FN] = n_res[7];
      n_flg[FS] = n_res[7] ^ n_flg[FV];
    end
  end

  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_idx   <= '0;
      result    <= '0;
      wr_en     <= 1'b0;
      flags_out <= '0;
      primed    <= 1'b0;
    end else begin
      dst_idx   <= instr[8:4];
      result    <= n_res;
      wr_en     <= n_wr;
      flags_out <= n_flg;
      primed    <= 1'b1;
    end
  end

  a_r3_sign_rule: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> flags_out[FS] == (flags_out[FN] ^ flags_out[FV]));
  a_r3_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> flags_out[FZ] == (result == 8'h00));
  a_r3_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> flags_out[FN] == result[7]);
  a_r3_high_pass: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> flags_out[7:6] == $past(flags_in[7:6]));
  a_r12_no_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !wr_en) |-> flags_out == $past(flags_in));
  a_r2_dest: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> dst_idx == $past(instr[8:4]));
  a_r7_r8_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(is_one && (instr[3:0] == 4'h3 || instr[3:0] == 4'ha)))
      |-> flags_out[FC] == $past(flags_in[FC]));
endmodule

// File: tb/sim_alu8_flags.sv
module sim_alu8_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic [7:0] opd_a = '0, opd_b = '0, flags_in = '0;
  logic [4:0] dst_idx;
  logic [7:0] result, flags_out;
  logic wr_en;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu8_flags u0 (.clk(clk), .rst_n(rst_n), .instr(instr), .opd_a(opd_a),
    .opd_b(opd_b), .flags_in(flags_in), .dst_idx(dst_idx), .result(result),
    .wr_en(wr_en), .flags_out(flags_out));

  function automatic logic [21:0] model(input logic [15:0] ins, input logic [7:0] a,
                                        input logic [7:0] b, input logic [7:0] f);
    logic [7:0] r, g;
    logic w;
    int s;
    g = f; r = 8'h00; w = 1'b1;
    if (ins[15:10] == 6'b000111) begin
      s = int'(a) + int'(b) + int'(f[0]);
      r = s[7:0];
      g[0] = s > 255;
      g[5] = (int'(a[3:0]) + int'(b[3:0]) + int'(f[0])) > 15;
      g[3] = ($signed(a) + $signed(b) + int'(f[0]) > 127) || ($signed(a) + $signed(b) + int'(f[0]) < -128);
    end else if (ins[15:9] == 7'b1001010 && ins[3:0] == 4'd0) begin
      r = 8'hff - a; g[3] = 0; g[0] = 1;
    end else if (ins[15:9] == 7'b1001010 && ins[3:0] == 4'd1) begin
      s = (256 - int'(a)) % 256; r = s[7:0];
      g[0] = s != 0; g[3] = s == 128; g[5] = r[3] | a[3];
    end else if (ins[15:9] == 7'b1001010 && ins[3:0] == 4'd3) begin
      s = (int'(a) + 1) % 256; r = s[7:0]; g[3] = s == 128;
    end else if (ins[15:9] == 7'b1001010 && ins[3:0] == 4'd10) begin
      s = (int'(a) + 255) % 256; r = s[7:0]; g[3] = a == 8'd128;
    end else if (ins[15:9] == 7'b1001010 && (ins[3:0] == 4'd5 || ins[3:0] == 4'd6 || ins[3:0] == 4'd7)) begin
      s = int'(a) / 2;
      if (ins[3:0] == 4'd5 && a >= 128) s = s + 128;
      if (ins[3:0] == 4'd7 && f[0]) s = s + 128;
      r = s[7:0];
      g[0] = a % 2 == 1;
      g[3] = (s >= 128) != (a % 2 == 1);
    end else w = 1'b0;
    if (w) begin
      g[1] = r == 0; g[2] = r >= 128; g[4] = g[2] != g[3];
    end
    return {w, r, g, 5'(ins[8:4])};
  endfunction

  task automatic run(input string tag, input logic [15:0] ins, input logic [7:0] a,
                     input logic [7:0] b, input logic [7:0] f);
    logic [21:0] e;
    @(negedge clk);
    instr = ins; opd_a = a; opd_b = b; flags_in = f;
    e = model(ins, a, b, f);
    @(posedge clk); #1;
    total++;
    if ({wr_en, result, flags_out, dst_idx} !== e) begin
      bad++;
      $display("FAIL %s ins=%h a=%h b=%h f=%h: got w=%b r=%h f=%h d=%0d exp w=%b r=%h f=%h d=%0d",
        tag, ins, a, b, f, wr_en, result, flags_out, dst_idx, e[21], e[20:13], e[12:5], e[4:0]);
    end
  endtask

  function automatic logic [7:0] fl(input int a, input int b, input int c);
    fl = 8'((a * 37 + b * 11 + 5) & 8'hfe) | 8'(c);
  endfunction

  initial begin
    #400000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    instr = 16'h1c00; opd_a = 8'hff; opd_b = 8'hff; flags_in = 8'hff;
    repeat (3) @(posedge clk);
    #1;
    total++;
    if ({dst_idx, result, wr_en, flags_out} !== '0) begin
      bad++;
      $display("FAIL R1 reset outputs got %h/%h/%b/%h exp 0", dst_idx, result, wr_en, flags_out);
    end
    @(negedge clk); rst_n = 1'b1;
    // R2 R3 R4: full add sweep with both carry values
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int c = 0; c < 2; c++)
          run("R4 add", {6'b000111, 1'(b >> 4), 5'(a), 4'(b)}, 8'(a), 8'(b), fl(a, b, c));
    // R5..R11: every single-operand op over all operands and both carry values
    begin
      logic [3:0] sel [7] = '{4'd0, 4'd1, 4'd3, 4'd10, 4'd5, 4'd6, 4'd7};
      string nm [7] = '{"R5 invert", "R6 negate", "R7 increment", "R8 decrement",
                        "R9 arith shift", "R10 logic shift", "R11 rotate"};
      for (int k = 0; k < 7; k++)
        for (int a = 0; a < 256; a++)
          for (int c = 0; c < 2; c++)
            run(nm[k], {7'b1001010, 5'(a + k), sel[k]}, 8'(a), 8'(255 - a), fl(a, k, c));
    end
    // R12: unused selectors and foreign opcodes leave status alone
    begin
      logic [3:0] us [9] = '{4'd2, 4'd4, 4'd8, 4'd9, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15};
      for (int k = 0; k < 9; k++)
        for (int a = 0; a < 8; a++)
          run("R12 unused selector", {7'b1001010, 5'(a * 3), us[k]}, 8'(a * 29), 8'h11, fl(a, k, a & 1));
      for (int a = 0; a < 64; a++)
        run("R12 other opcode", {6'(a == 7 ? 8 : a), 10'(a * 97)}, 8'(a), 8'(a * 5), fl(a, 3, a & 1));
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule